// File: doc/BRIEF.md
# RC6 Iterative Block Encryptor

This block turns one 128-bit plaintext block into a 128-bit RC6 ciphertext block. It uses one round datapath and runs one round per clock. The block is held as four 32-bit words A, B, C and D, packed into the bus with A in bits [31:0], B in [63:32], C in [95:64] and D in [127:96]. The ciphertext uses the same packing. Each round forms two quadratic mixing values, one from B and one from D. These feed two rotate-and-add units. A word swap then passes the results on to the next round.

Key expansion takes place outside the block. The block asks for subkeys in pairs. The pair index and a 2-bit key-set number go out on `key_pair_o` and `kset_o`, and the matching even and odd subkeys come back combinationally on `key_even_i` and `key_odd_i`. Pair p carries subkeys S[2p] and S[2p+1]. The key-set counter steps to the next set after each accepted block, so the same plaintext sent again produces a different ciphertext.

The handshake works as follows. When `start_i` is high while `ready_o` is high, the block is accepted. `ready_o` then stays low until the ciphertext appears. `done_o` pulses for one cycle when `ct_o` becomes valid.

Top module: `rc6_enc_core`

## Requirements
- R1: After reset, `ready_o`=1, `done_o`=0, `ct_o`=0 and `kset_o`=0.
- R2: The mixing value for a word x is (x·(2x+1) mod 2^32) rotated left by 5. The rotation amount used by a rotate-and-add unit is the low 5 bits of the other mixing value, so every rotation amount is taken modulo 32.
- R3: The sequence of operations is as follows:
  - Before the rounds, B gets S0 added and D gets S1 added.
  - Round i (1..20) sets A' = rotl(A^t, u mod 32) + S[2i] and C' = rotl(C^u, t mod 32) + S[2i+1].
  - After each round, (A, B, C, D) becomes (B, C', D, A').
  - After round 20, A gets S42 added and C gets S43 added.
  - All additions are modulo 2^32.
  - With an all-zero key schedule input and all-zero plaintext, the packed ciphertext is 1ea44898_4edf29c1_78f7b156_36a5c38f.
- R4: `key_pair_o` is 0 while the block is idle, including the cycle in which start is accepted. It reads k in the cycle that computes round k, and 21 in the final cycle.
- R5: `done_o` is high for exactly one cycle. It rises 21 clock edges after the edge that accepts start.
- R6: `ready_o` is low from the accepting edge until `done_o` rises. A `start_i` that arrives while `ready_o` is low has no effect on the result or on the key set.
- R7: The key-set counter resets to 0 and advances by one for each accepted block, wrapping from 3 to 0. A block uses the key set that `kset_o` shows in its accept cycle.
- R8: `ct_o` holds its value from one `done_o` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to encrypt `pt_i` |
| pt_i | input | 128 | Plaintext, D:C:B:A from most to least significant |
| ready_o | output | 1 | Block can accept a start |
| done_o | output | 1 | One-cycle pulse, ciphertext valid |
| ct_o | output | 128 | Ciphertext, same packing as `pt_i` |
| key_pair_o | output | 5 | Subkey pair index p (S[2p], S[2p+1]) |
| kset_o | output | 2 | Key-set number for the subkey read |
| key_even_i | input | 32 | Subkey S[2p] of the selected set |
| key_odd_i | input | 32 | Subkey S[2p+1] of the selected set |

## Verification
The assertions check several properties on every cycle:
- the protocol: ready drops after an accept, done lasts one cycle and coincides with ready;
- the subkey pair index steps once per cycle while busy and stays within bounds;
- the key set stays stable while idle without a start;
- the ciphertext stays stable between done pulses.

The arithmetic can only be shown by the bench scenarios. Ciphertexts are compared against an independent reference model and a known all-zero answer. The same scenarios show that key sets rotate with wrap-around, and that a start issued in the middle of a block is ignored.

// File: rtl/rc6_pkg.sv
package rc6_pkg;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned KSET_W = 2;
  parameter int unsigned ROUNDS_DEF = 20;
  localparam int unsigned LOG_W = $clog2(WORD_W);
  localparam int unsigned BLK_W = 4 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t d;
    word_t c;
    word_t b;
    word_t a;
  } blk_t;

  function automatic word_t rotl(word_t x, logic [LOG_W-1:0] n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << n;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction
endpackage

// File: rtl/rc6_mix.sv
module rc6_mix
  import rc6_pkg::*;
(
  input  word_t x_i,
  output word_t f_o
);
  word_t prod;
  assign prod = x_i * {x_i[WORD_W-2:0], 1'b1};
  assign f_o  = rotl(prod, LOG_W'(LOG_W));
endmodule

// File: rtl/rc6_half.sv
module rc6_half
  import rc6_pkg::*;
(
  input  word_t            x_i,
  input  word_t            mix_i,
  input  logic [LOG_W-1:0] amt_i,
  input  word_t            key_i,
  output word_t            y_o
);
  assign y_o = rotl(x_i ^ mix_i, amt_i) + key_i;
endmodule

// File: rtl/rc6_round.sv
module rc6_round
  import rc6_pkg::*;
(
  input  blk_t  st_i,
  input  word_t key_even_i,
  input  word_t key_odd_i,
  output blk_t  st_o
);
  word_t t, u, a_new, c_new;

  rc6_mix u_mix_t (.x_i(st_i.b), .f_o(t));
  rc6_mix u_mix_u (.x_i(st_i.d), .f_o(u));

  rc6_half u_half_a (
    .x_i(st_i.a), .mix_i(t), .amt_i(u[LOG_W-1:0]), .key_i(key_even_i), .y_o(a_new)
  );
  rc6_half u_half_c (
    .x_i(st_i.c), .mix_i(u), .amt_i(t[LOG_W-1:0]), .key_i(key_odd_i), .y_o(c_new)
  );

  // word rotation: A<-B, B<-C', C<-D, D<-A'
  always_comb begin
    st_o.a = st_i.b;
    st_o.b = c_new;
    st_o.c = st_i.d;
    st_o.d = a_new;
  end
endmodule

// File: rtl/rc6_kset_ctr.sv
module rc6_kset_ctr
  import rc6_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [KSET_W-1:0] set_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     set_o <= '0;
    else if (step_i) set_o <= set_o + 1'b1;
  end
endmodule

// File: rtl/rc6_enc_core.sv
module rc6_enc_core
  import rc6_pkg::*;
#(
  parameter int unsigned ROUNDS = ROUNDS_DEF,
  localparam int unsigned PAIR_W = $clog2(ROUNDS + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BLK_W-1:0]  pt_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [BLK_W-1:0]  ct_o,
  output logic [PAIR_W-1:0] key_pair_o,
  output logic [KSET_W-1:0] kset_o,
  input  logic [WORD_W-1:0] key_even_i,
  input  logic [WORD_W-1:0] key_odd_i
);
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(ROUNDS + 1);

  blk_t              st_q, rnd_out, pt_w, ct_w;
  logic              busy_q, done_q, accept;
  logic [PAIR_W-1:0] rnd_q;
  logic [KSET_W-1:0] ctr_set, blk_set_q;
  blk_t              ct_q;

  assign accept = start_i && !busy_q;
  assign pt_w   = blk_t'(pt_i);

  rc6_kset_ctr u_kset (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(accept), .set_o(ctr_set)
  );

  rc6_round u_round (
    .st_i(st_q), .key_even_i(key_even_i), .key_odd_i(key_odd_i), .st_o(rnd_out)
  );

  // output whitening on the last pair
  always_comb begin
    ct_w   = st_q;
    ct_w.a = st_q.a + key_even_i;
    ct_w.c = st_q.c + key_odd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= '0;
      busy_q    <= 1'b0;
      rnd_q     <= '0;
      done_q    <= 1'b0;
      ct_q      <= '0;
      blk_set_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st_q      <= pt_w;
        st_q.b    <= pt_w.b + key_even_i;
        st_q.d    <= pt_w.d + key_odd_i;
        busy_q    <= 1'b1;
        rnd_q     <= PAIR_W'(1);
        blk_set_q <= ctr_set;
      end else if (busy_q) begin
        if (rnd_q == LAST_PAIR) begin
          ct_q   <= ct_w;
          done_q <= 1'b1;
          busy_q <= 1'b0;
          rnd_q  <= '0;
        end else begin
          st_q  <= rnd_out;
          rnd_q <= rnd_q + 1'b1;
        end
      end
    end
  end

  assign ready_o    = !busy_q;
  assign done_o     = done_q;
  assign ct_o       = ct_q;
  assign key_pair_o = busy_q ? rnd_q : '0;
  assign kset_o     = busy_q ? blk_set_q : ctr_set;
endmodule

// File: rtl/rc6_enc_core_chk.sv
module rc6_enc_core_chk
  import rc6_pkg::*;
#(
  parameter int unsigned ROUNDS = ROUNDS_DEF,
  localparam int unsigned PAIR_W = $clog2(ROUNDS + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ready_o,
  input logic              done_o,
  input logic [BLK_W-1:0]  ct_o,
  input logic [PAIR_W-1:0] key_pair_o,
  input logic [KSET_W-1:0] kset_o
);
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(ROUNDS + 1);

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  // R6
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !ready_o);

  // R4
  pair_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (key_pair_o == '0));

  // R4
  pair_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && key_pair_o != LAST_PAIR) |=> (key_pair_o == $past(key_pair_o) + 1'b1));

  // R4
  pair_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_pair_o <= LAST_PAIR);

  // R7
  kset_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> $stable(kset_o));

  // R8
  ct_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || $stable(ct_o)));
endmodule

bind rc6_enc_core rc6_enc_core_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_o(ready_o),
  .done_o(done_o), .ct_o(ct_o), .key_pair_o(key_pair_o), .kset_o(kset_o)
);

// File: tb/tb_rc6_enc_core.sv
module tb_rc6_enc_core;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         start_i;
  logic [127:0] pt_i;
  logic         ready_o, done_o;
  logic [127:0] ct_o;
  logic [4:0]   key_pair_o;
  logic [1:0]   kset_o;
  logic [31:0]  key_even_i, key_odd_i;

  logic [31:0] sk [4][44];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  rc6_enc_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pt_i(pt_i),
    .ready_o(ready_o), .done_o(done_o), .ct_o(ct_o), .key_pair_o(key_pair_o),
    .kset_o(kset_o), .key_even_i(key_even_i), .key_odd_i(key_odd_i)
  );

  always_comb begin
    key_even_i = sk[int'(kset_o)][2*int'(key_pair_o)];
    key_odd_i  = sk[int'(kset_o)][2*int'(key_pair_o)+1];
  end

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    n = n % 32;
    return (x << n) | (x >> (32 - n));
  endfunction

  task automatic make_set(input int s, input logic [127:0] key);
    logic [31:0] l [4];
    logic [31:0] a, b;
    int i, j;
    for (int k = 0; k < 4; k++) l[k] = key[32*k +: 32];
    sk[s][0] = 32'hB7E15163;
    for (int k = 1; k < 44; k++) sk[s][k] = sk[s][k-1] + 32'h9E3779B9;
    a = '0; b = '0; i = 0; j = 0;
    for (int k = 0; k < 132; k++) begin
      a = rl(sk[s][i] + a + b, 3);
      sk[s][i] = a;
      b = rl(l[j] + a + b, int'((a + b) & 32'd31));
      l[j] = b;
      i = (i + 1) % 44;
      j = (j + 1) % 4;
    end
  endtask

  function automatic logic [127:0] model(logic [127:0] pt, int s);
    logic [31:0] a, b, c, d, t, u, na, nc;
    {d, c, b, a} = pt;
    b = b + sk[s][0];
    d = d + sk[s][1];
    for (int r = 1; r <= 20; r++) begin
      t  = rl(b * (2 * b + 1), 5);
      u  = rl(d * (2 * d + 1), 5);
      na = rl(a ^ t, int'(u & 32'd31)) + sk[s][2*r];
      nc = rl(c ^ u, int'(t & 32'd31)) + sk[s][2*r+1];
      a = b; b = nc; c = d; d = na;
    end
    a = a + sk[s][42];
    c = c + sk[s][43];
    return {d, c, b, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // runs one block; poke_at >= 0 raises start with other data mid-block
  task automatic encrypt(input logic [127:0] pt, input int poke_at,
                         output logic [127:0] ct, output int lat);
    bit pair_ok = 1'b1, rdy_ok = 1'b1;
    @(negedge clk_i);
    pt_i = pt;
    start_i = 1'b1;
    chk(ready_o == 1'b1, "R6", "ready before start", 128'(ready_o), 128'd1);
    chk(key_pair_o == 5'd0, "R4", "pair at accept", 128'(key_pair_o), 128'd0);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 100) begin
      if (key_pair_o != 5'(lat + 1)) pair_ok = 1'b0;
      if (ready_o) rdy_ok = 1'b0;
      start_i = (lat == poke_at);
      if (start_i) pt_i = ~pt;
      @(negedge clk_i);
      lat++;
    end
    start_i = 1'b0;
    ct = ct_o;
    chk(pair_ok, "R4", "pair sequence", 128'(key_pair_o), 128'd0);
    chk(rdy_ok, "R6", "ready low while busy", 128'(ready_o), 128'd0);
    chk(lat == 21, "R5", "done latency", 128'(lat), 128'd21);
    chk(ready_o == 1'b1, "R5", "ready with done", 128'(ready_o), 128'd1);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R5", "done one cycle", 128'(done_o), 128'd0);
  endtask

  task automatic t_reset();
    chk(ready_o == 1'b1, "R1", "reset ready", 128'(ready_o), 128'd1);
    chk(done_o == 1'b0, "R1", "reset done", 128'(done_o), 128'd0);
    chk(ct_o == '0, "R1", "reset ct", ct_o, 128'd0);
    chk(kset_o == 2'd0, "R1", "reset kset", 128'(kset_o), 128'd0);
  endtask

  task automatic t_known_answer();
    logic [127:0] ct;
    int lat;
    encrypt('0, -1, ct, lat);
    chk(ct == 128'h1ea44898_4edf29c1_78f7b156_36a5c38f, "R3", "zero-key answer",
        ct, 128'h1ea44898_4edf29c1_78f7b156_36a5c38f);
    chk(ct == model('0, 0), "R2", "mix model set0", ct, model('0, 0));
  endtask

  task automatic t_key_rotation();
    logic [127:0] pt = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    logic [127:0] ct, first;
    int lat;
    for (int n = 0; n < 5; n++) begin
      int s = (n + 1) % 4;
      @(negedge clk_i);
      chk(kset_o == 2'(s), "R7", "kset before start", 128'(kset_o), 128'(s));
      encrypt(pt, -1, ct, lat);
      chk(ct == model(pt, s), "R7", "ct uses set", ct, model(pt, s));
      if (n == 0) first = ct;
      if (n == 1) chk(ct != first, "R7", "sets differ", ct, first);
      if (n == 4) chk(ct == first, "R7", "wrap to same set", ct, first);
    end
  endtask

  task automatic t_patterns();
    logic [127:0] pats [5];
    logic [127:0] ct;
    int lat;
    pats[0] = '1;
    pats[1] = {4{32'hAAAA5555}};
    pats[2] = 128'h00000004_00000003_00000002_00000001;
    pats[3] = 128'hffffffff_00000000_ffffffff_00000000;
    pats[4] = 128'h80000000_7fffffff_0000001f_deadbeef;
    for (int k = 0; k < 5; k++) begin
      int s = int'(kset_o);
      encrypt(pats[k], -1, ct, lat);
      chk(ct == model(pats[k], s), "R3", "pattern vs model", ct, model(pats[k], s));
    end
  endtask

  task automatic t_busy_start();
    logic [127:0] pt = 128'hcafef00d_00c0ffee_12345678_9abcdef0;
    logic [127:0] ct;
    int lat;
    int s = int'(kset_o);
    encrypt(pt, 7, ct, lat);
    chk(ct == model(pt, s), "R6", "mid-block start ignored", ct, model(pt, s));
    chk(kset_o == 2'((s + 1) % 4), "R6", "kset advanced once", 128'(kset_o),
        128'((s + 1) % 4));
  endtask

  task automatic t_hold();
    logic [127:0] held = ct_o;
    bit stable = 1'b1, quiet = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk_i);
      if (ct_o != held) stable = 1'b0;
      if (done_o) quiet = 1'b0;
    end
    chk(stable, "R8", "ct held while idle", ct_o, held);
    chk(quiet, "R5", "no spurious done", 128'(done_o), 128'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    start_i = 1'b0;
    pt_i = '0;
    make_set(0, '0);
    make_set(1, 128'h00112233_44556677_8899aabb_ccddeeff);
    make_set(2, 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0);
    make_set(3, 128'hffffffff_00000001_13579bdf_2468ace0);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_known_answer();
    t_key_rotation();
    t_patterns();
    t_busy_start();
    t_hold();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule